// File: doc/BRIEF.md
# Header-Based Routing Forwarder

This block accepts one 72-bit routing unit per cycle and decides where it goes. The top byte of the unit is a header that holds a destination node number and a message type; the remaining 64 bits are payload. The destination number indexes a routing table. Each table entry says either "this node is the final stop" or "send the unit out on outbound port N". A unit for this node leaves on the local delivery strobe. Any other unit leaves on the strobe of its outbound port. If that port is marked as failed by its link-down input, the unit leaves on the error strobe instead.

Software or a link manager can rewrite table entries at any time through a simple write port. This lets traffic be moved off a dead link while units keep flowing. The decision is registered, so each unit appears on the outputs exactly one cycle after it is presented. The message type bits are carried through unchanged and are not interpreted.

The output stage is a small dispatch state machine with four states. `DISP_IDLE` means no unit is out. `DISP_LOCAL`, `DISP_FWD` and `DISP_ERR` each mean a unit is presented on the matching strobe. Every cycle the machine moves to the state that the classifier picks for the current input. That pick is `DISP_IDLE` when `in_valid` is low, `DISP_LOCAL` when the entry's local flag is set, `DISP_ERR` when the chosen port is down, and `DISP_FWD` otherwise. Any state can follow any other.

Top module: `unit_router`

## Requirements
- R1: A unit is 72 bits. The header sits in bits 71:64, with the destination number in bits 71:67 and the message type in bits 66:64. The payload sits in bits 63:0. The whole unit, type field included, appears unchanged on `out_unit` alongside its strobe.
- R2: A unit presented with `in_valid` high produces exactly one strobe in the next cycle. A cycle with `in_valid` low produces no strobe in the next cycle.
- R3: When the looked-up entry has its local flag set, the unit is delivered on `loc_valid`.
- R4: When the local flag is clear, the unit goes out on `fwd_valid[p]`, where p is the entry's 2-bit port field.
- R5: When the local flag is clear and `link_down[p]` is high in the cycle the unit is presented, the unit is raised on `err_valid` and no forward strobe is raised.
- R6: Local delivery ignores `link_down`, even when all ports are down.
- R7: With `tbl_we` high, entry `tbl_addr` is loaded with local flag `tbl_local` and port `tbl_port`. Lookups in later cycles use the new contents.
- R8: When a write and a lookup hit the same entry in the same cycle, the lookup uses the entry's contents from before the write.
- R9: Reset sets every table entry to local flag 1, port 0, and holds all strobes low.
- R10: At most one of `loc_valid`, the `fwd_valid` bits and `err_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Unit present on `in_unit` |
| in_unit | input | 72 | Incoming routing unit |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 5 | Entry to write |
| tbl_port | input | 2 | Outbound port to store |
| tbl_local | input | 1 | Local flag to store |
| link_down | input | 4 | Per-port failed-link marks |
| loc_valid | output | 1 | Unit delivered to this node |
| fwd_valid | output | 4 | Unit forwarded on the given port |
| err_valid | output | 1 | Unit targeted a port that is down |
| out_unit | output | 72 | Unit accompanying the active strobe |

## Verification
The hardest case to reach from the ports is the collision where a table write and a lookup hit the same entry in one cycle. Here the stale contents must win, and the new contents must take over on the very next unit. The stimulus table drives `tbl_we` and `in_valid` together with matching address and destination, in two ways. One flips an entry from local to forwarded. The other moves a forwarded entry to a new port. A follow-up vector then looks up the same entry again to show the update landed. Link-down masks are varied around these entries so that each port's health is checked against both the old and the new port choice.

// File: rtl/unit_router_pkg.sv
package unit_router_pkg;

    localparam int DEST_W_DEF  = 5;
    localparam int TYPE_W_DEF  = 3;
    localparam int PAY_W_DEF   = 64;
    localparam int N_PORTS_DEF = 4;

    // dispatch state of the output stage
    typedef enum logic [1:0] {
        DISP_IDLE  = 2'd0,
        DISP_LOCAL = 2'd1,
        DISP_FWD   = 2'd2,
        DISP_ERR   = 2'd3
    } disp_e;

endpackage

// File: rtl/route_table.sv
module route_table #(
    parameter int DEPTH  = 32,
    parameter int PORT_W = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int ENT_W  = PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wentry,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rentry
);

    // entry layout: {local_flag, port}
    logic [ENT_W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= {1'b1, {PORT_W{1'b0}}};
            end else if (we && (waddr == ADDR_W'(g))) begin
                ent[g] <= wentry;
            end
        end
    end

    // read of the stored value: a same-cycle write is not yet visible
    assign rentry = ent[raddr];

    // R7: a write lands in the addressed entry
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ent[$past(waddr)] == $past(wentry)));

endmodule

// File: rtl/route_classify.sv
module route_classify
    import unit_router_pkg::*;
#(
    parameter int N_PORTS = 4,
    localparam int PORT_W = $clog2(N_PORTS),
    localparam int ENT_W  = PORT_W + 1
) (
    input  logic               in_valid,
    input  logic [ENT_W-1:0]   entry,
    input  logic [N_PORTS-1:0] link_down,
    output disp_e              next_state,
    output logic [PORT_W-1:0]  next_port
);

    logic              is_local;
    logic [PORT_W-1:0] sel_port;

    assign is_local = entry[ENT_W-1];
    assign sel_port = entry[PORT_W-1:0];

    always_comb begin
        next_port = sel_port;
        if (!in_valid) begin
            next_state = DISP_IDLE;
        end else if (is_local) begin
            next_state = DISP_LOCAL;
        end else if (link_down[sel_port]) begin
            next_state = DISP_ERR;
        end else begin
            next_state = DISP_FWD;
        end
    end

endmodule

// File: rtl/route_dispatch.sv
module route_dispatch
    import unit_router_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int UNIT_W  = 72,
    localparam int PORT_W = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  disp_e              next_state,
    input  logic [PORT_W-1:0]  next_port,
    input  logic [UNIT_W-1:0]  in_unit,
    output logic               loc_valid,
    output logic [N_PORTS-1:0] fwd_valid,
    output logic               err_valid,
    output logic [UNIT_W-1:0]  out_unit
);

    disp_e             state;
    logic [PORT_W-1:0] port_q;
    logic [UNIT_W-1:0] unit_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DISP_IDLE;
            port_q <= '0;
            unit_q <= '0;
        end else begin
            state <= next_state;
            if (next_state != DISP_IDLE) begin
                port_q <= next_port;
                unit_q <= in_unit;
            end
        end
    end

    // outputs from state
    always_comb begin
        loc_valid = 1'b0;
        fwd_valid = '0;
        err_valid = 1'b0;
        unique case (state)
            DISP_IDLE:  ;
            DISP_LOCAL: loc_valid = 1'b1;
            DISP_FWD:   fwd_valid[port_q] = 1'b1;
            DISP_ERR:   err_valid = 1'b1;
        endcase
    end

    assign out_unit = unit_q;

    // R10: strobes are mutually exclusive
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_valid, fwd_valid, err_valid}));

endmodule

// File: rtl/unit_router.sv
module unit_router
    import unit_router_pkg::*;
#(
    parameter int DEST_W  = DEST_W_DEF,
    parameter int TYPE_W  = TYPE_W_DEF,
    parameter int PAY_W   = PAY_W_DEF,
    parameter int N_PORTS = N_PORTS_DEF,
    localparam int HDR_W  = DEST_W + TYPE_W,
    localparam int UNIT_W = HDR_W + PAY_W,
    localparam int DEPTH  = 1 << DEST_W,
    localparam int PORT_W = $clog2(N_PORTS),
    localparam int ENT_W  = PORT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [UNIT_W-1:0]  in_unit,
    input  logic               tbl_we,
    input  logic [DEST_W-1:0]  tbl_addr,
    input  logic [PORT_W-1:0]  tbl_port,
    input  logic               tbl_local,
    input  logic [N_PORTS-1:0] link_down,
    output logic               loc_valid,
    output logic [N_PORTS-1:0] fwd_valid,
    output logic               err_valid,
    output logic [UNIT_W-1:0]  out_unit
);

    logic [DEST_W-1:0] dest_id;
    logic [ENT_W-1:0]  look_entry;
    disp_e             nxt_state;
    logic [PORT_W-1:0] nxt_port;

    // destination sits at the top of the header
    assign dest_id = in_unit[UNIT_W-1 -: DEST_W];

    route_table #(
        .DEPTH  (DEPTH),
        .PORT_W (PORT_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .wentry ({tbl_local, tbl_port}),
        .raddr  (dest_id),
        .rentry (look_entry)
    );

    route_classify #(
        .N_PORTS (N_PORTS)
    ) u_classify (
        .in_valid   (in_valid),
        .entry      (look_entry),
        .link_down  (link_down),
        .next_state (nxt_state),
        .next_port  (nxt_port)
    );

    route_dispatch #(
        .N_PORTS (N_PORTS),
        .UNIT_W  (UNIT_W)
    ) u_dispatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (nxt_state),
        .next_port  (nxt_port),
        .in_unit    (in_unit),
        .loc_valid  (loc_valid),
        .fwd_valid  (fwd_valid),
        .err_valid  (err_valid),
        .out_unit   (out_unit)
    );

    // R2: a presented unit yields a strobe one cycle later
    a_r2_unit_emerges: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (loc_valid || (|fwd_valid) || err_valid));

    // R2: an idle cycle yields no strobe one cycle later
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(loc_valid || (|fwd_valid) || err_valid));

    // R1: the unit carried out is the unit presented
    a_r1_unit_intact: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_unit == $past(in_unit)));

    // R5: never forward on a port that was down when the unit arrived
    for (genvar p = 0; p < N_PORTS; p++) begin : g_down_chk
        a_r5_no_dead_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_valid[p] |-> !$past(link_down[p]));
    end

endmodule

// File: tb/unit_router_tb.sv
`timescale 1ns/100ps
module unit_router_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [71:0] in_unit;
    logic        tbl_we;
    logic [4:0]  tbl_addr;
    logic [1:0]  tbl_port;
    logic        tbl_local;
    logic [3:0]  link_down;
    logic        loc_valid;
    logic [3:0]  fwd_valid;
    logic        err_valid;
    logic [71:0] out_unit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    unit_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_unit   (in_unit),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_port  (tbl_port),
        .tbl_local (tbl_local),
        .link_down (link_down),
        .loc_valid (loc_valid),
        .fwd_valid (fwd_valid),
        .err_valid (err_valid),
        .out_unit  (out_unit)
    );

    // expected kind: 0 none, 1 local, 2 forward, 3 error
    typedef struct packed {
        logic       we;
        logic [4:0] wa;
        logic [1:0] wp;
        logic       wl;
        logic       iv;
        logic [4:0] dst;
        logic [2:0] typ;
        logic [3:0] dn;
        logic [1:0] ek;
        logic [1:0] ep;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd3,  3'd1, 4'b0000, 2'd1, 2'd0}, // R9 reset entry local
        '{1'b1, 5'd3,  2'd2, 1'b0, 1'b1, 5'd3,  3'd2, 4'b0000, 2'd1, 2'd0}, // R8 old value wins
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd3,  3'd3, 4'b0000, 2'd2, 2'd2}, // R7 new value seen
        '{1'b1, 5'd7,  2'd1, 1'b0, 1'b0, 5'd7,  3'd0, 4'b0000, 2'd0, 2'd0}, // R2 idle
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd7,  3'd4, 4'b0000, 2'd2, 2'd1}, // R4
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd7,  3'd5, 4'b0010, 2'd3, 2'd0}, // R5 own port down
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd7,  3'd6, 4'b1101, 2'd2, 2'd1}, // R5 others down
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd9,  3'd7, 4'b1111, 2'd1, 2'd0}, // R6 all down
        '{1'b1, 5'd3,  2'd3, 1'b0, 1'b1, 5'd3,  3'd0, 4'b0000, 2'd2, 2'd2}, // R8 port move
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd3,  3'd1, 4'b0100, 2'd2, 2'd3}, // R7 moved off port 2
        '{1'b1, 5'd31, 2'd0, 1'b0, 1'b0, 5'd0,  3'd0, 4'b0000, 2'd0, 2'd0}, // R2 idle
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd31, 3'd2, 4'b0000, 2'd2, 2'd0}, // R4 port 0
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd31, 3'd3, 4'b0001, 2'd3, 2'd0}, // R5
        '{1'b1, 5'd3,  2'd0, 1'b1, 1'b1, 5'd31, 3'd4, 4'b0000, 2'd2, 2'd0}, // R4
        '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1, 5'd3,  3'd5, 4'b1111, 2'd1, 2'd0}  // R7 back to local, R6
    };

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid  = 1'b0;
        in_unit   = '0;
        tbl_we    = 1'b0;
        tbl_addr  = '0;
        tbl_port  = '0;
        tbl_local = 1'b0;
        link_down = '0;
    endtask

    function automatic logic [5:0] strobes(input logic [1:0] ek, input logic [1:0] ep);
        logic [3:0] f;
        f = (ek == 2'd2) ? (4'b0001 << ep) : 4'b0000;
        return {ek == 2'd1, f, ek == 2'd3};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [71:0] sent;
        logic [1:0]  pk;
        logic [1:0]  pp;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: strobes low during reset
        chk("R9 strobes in reset", {66'd0, loc_valid, fwd_valid, err_valid}, 72'd0);
        rst_n = 1'b1;
        sent = '0;
        pk = 2'd0;
        pp = 2'd0;

        for (int i = 0; i < NV; i++) begin
            tbl_we    = VECS[i].we;
            tbl_addr  = VECS[i].wa;
            tbl_port  = VECS[i].wp;
            tbl_local = VECS[i].wl;
            in_valid  = VECS[i].iv;
            link_down = VECS[i].dn;
            in_unit   = {VECS[i].dst, VECS[i].typ, 32'hC0DE0000 + 32'(i), 32'h0BAD0000 ^ 32'(i)};
            sent = in_unit;
            pk = VECS[i].ek;
            pp = VECS[i].ep;
            @(negedge clk);
            case (pk)
                2'd0: chk("R2 no strobe", {66'd0, loc_valid, fwd_valid, err_valid}, {66'd0, strobes(pk, pp)});
                2'd1: chk("R3 local strobe", {66'd0, loc_valid, fwd_valid, err_valid}, {66'd0, strobes(pk, pp)});
                2'd2: chk("R4 forward strobe", {66'd0, loc_valid, fwd_valid, err_valid}, {66'd0, strobes(pk, pp)});
                default: chk("R5 error strobe", {66'd0, loc_valid, fwd_valid, err_valid}, {66'd0, strobes(pk, pp)});
            endcase
            chk("R10 single strobe", 72'($countones({loc_valid, fwd_valid, err_valid}) <= 1), 72'd1);
            if (pk != 2'd0) chk("R1 unit and type intact", out_unit, sent);
        end

        // R9: reset restores entry 7 (was forward on port 1) to local
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 strobes after reset", {66'd0, loc_valid, fwd_valid, err_valid}, 72'd0);
        rst_n = 1'b1;
        in_valid = 1'b1;
        in_unit  = {5'd7, 3'd2, 64'h1122334455667788};
        link_down = 4'b1111;
        @(negedge clk);
        chk("R9 entry back to local", {66'd0, loc_valid, fwd_valid, err_valid}, {66'd0, 6'b100000});
        chk("R1 payload after reset", out_unit, {5'd7, 3'd2, 64'h1122334455667788});
        idle_inputs();
        @(negedge clk);
        chk("R2 quiet after stream", {66'd0, loc_valid, fwd_valid, err_valid}, 72'd0);

        finish_run();
    end

endmodule